// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two threshold values that a queue's flag logic compares its fill level against: an almost-empty offset and an almost-full offset. Each offset is as wide as the queue's pointers. A master reset loads a preset into both offsets. The level of the configuration-select input during that reset picks the preset, either 127 or 1023. A partial reset clears only the access sequence and leaves the programmed values in place.

After reset, software can change the offsets in two ways. Parallel writes arrive on the data bus on write-clock edges. Serial bits arrive one per write-clock edge. The values can be read back on the read clock. Parallel accesses step through a fixed sequence of words. The almost-empty offset comes first and the almost-full offset second. An offset wider than 16 bits takes two words, low part first. Reads have their own sequence pointer, separate from the write one. While a parallel write sequence or a serial load is part-way through, the block raises an indication that the almost flags cannot be trusted.

When the configuration-select input is high, the write, read and serial strobes belong to the queue memory, and this block ignores them.

Top module: `flag_offset_loader`

## Requirements
- R1: A write-clock edge with `mrst_n` low and `cfg_sel` low sets both offsets to 127.
- R2: A write-clock edge with `mrst_n` low and `cfg_sel` high sets both offsets to 1023.
- R3: A partial reset (`prst_n` low) leaves both offsets unchanged. It returns the write and serial sequences to their start, returns the read sequence to its start, clears `rb_data` to 0 and drops `flags_invalid`.
- R4: A write-clock edge with `cfg_sel` low and `wr_en_n` low performs a parallel write. With the default width of 18, successive writes fill the following in order, then wrap to the first:
  - almost-empty bits 15:0 from `din[15:0]`
  - almost-empty bits 17:16 from `din[1:0]`
  - almost-full bits 15:0
  - almost-full bits 17:16
- R5: A read-clock edge with `cfg_sel` low and `rd_en_n` low loads the next word of the same four-step order into `rb_data`, and the read sequence then wraps. The bits of a word are zero-extended into `rb_data`. In all other cases `rb_data` holds its value.
- R6: A write-clock edge with `cfg_sel` low, `wr_en_n` high and `ser_en_n` low shifts `ser_din` in. After 2×OFS_W shifts, the first bit shifted has become almost-empty bit 0 and the last has become almost-full bit OFS_W-1.
- R7: While `cfg_sel` is high, the offsets, `flags_invalid` and `rb_data` do not change, whatever the strobes do.
- R8: `flags_invalid` is high exactly when the parallel write sequence is not at its first word, or when the serial bit count is not a multiple of 2×OFS_W.
- R9: When `wr_en_n` and `ser_en_n` are both low with `cfg_sel` low, the parallel write takes effect and no serial bit is shifted.
- R10: Read-back does not change the offsets or the write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous to each clock |
| prst_n | input | 1 | Partial reset, active low, synchronous to each clock |
| cfg_sel | input | 1 | Low: strobes access the offsets. Level during master reset picks the preset |
| wr_en_n | input | 1 | Parallel write strobe, active low |
| rd_en_n | input | 1 | Read-back strobe, active low |
| ser_en_n | input | 1 | Serial shift strobe, active low |
| ser_din | input | 1 | Serial data bit |
| din | input | DATA_W | Parallel write data |
| ae_offset | output | OFS_W | Almost-empty offset |
| af_offset | output | OFS_W | Almost-full offset |
| rb_data | output | DATA_W | Read-back word |
| flags_invalid | output | 1 | High while offset programming is part-way through |

## Verification
The assertions assume the following about the inputs:
- Both resets and `cfg_sel` are stable around both clock edges.
- The read clock does not read back an offset in the same cycle that the write side changes it.

The bench keeps within these limits by changing every input only on the falling edge of the write clock. The read clock's rising edge falls five nanoseconds after the write clock's, so each operation lasts one full write period and both edges see settled levels. Random operations are issued one at a time and mix parallel writes, serial bits, read-backs, blocked strobes and both resets.

// File: rtl/ofl_pkg.sv
// Package: shared constants and the decoded write-side operation type for
// the flag offset loader. Assumes a parallel word is 16 bits wide.
package ofl_pkg;
    localparam int PAR_WORD_W = 16;
    localparam int DEF_LO     = 127;
    localparam int DEF_HI     = 1023;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PWR   = 2'd1,
        OP_SHIFT = 2'd2
    } wr_op_e;
endpackage

// File: rtl/ofs_seq_ctr.sv
// Module: wrapping step counter used for the parallel word sequences and the
// serial bit count. Counts 0..MAX-1 and wraps to 0.
// Assumes MAX >= 2 and a synchronous active-low clear.
module ofs_seq_ctr #(
    parameter  int MAX = 4,
    localparam int CW  = (MAX > 1) ? $clog2(MAX) : 1
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          adv,
    output logic [CW-1:0] cnt
);
    // Step register: clear, advance with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            cnt <= '0;
        end else if (adv) begin
            if (cnt == CW'(MAX - 1)) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/ofs_word_merge.sv
// Module: merges one parallel data word into an offset value.
// For offsets wider than one parallel word, word_hi selects the upper part,
// which is taken from the low bits of din. Assumes DATA_W >= 16 and
// OFS_W <= 32.
module ofs_word_merge #(
    parameter int OFS_W  = 18,
    parameter int DATA_W = 18
) (
    input  logic [OFS_W-1:0]  cur,
    input  logic [DATA_W-1:0] din,
    input  logic              word_hi,
    output logic [OFS_W-1:0]  nxt
);
    localparam int LW = ofl_pkg::PAR_WORD_W;

    if (OFS_W > LW) begin : g_two
        localparam int HI_W = OFS_W - LW;
        // Replace either the upper or the lower part of the offset.
        always_comb begin
            if (word_hi) begin
                nxt = {din[HI_W-1:0], cur[LW-1:0]};
            end else begin
                nxt = {cur[OFS_W-1:LW], din[LW-1:0]};
            end
        end
        if (DATA_W > LW) begin : g_sink
            logic unused_din_top;
            assign unused_din_top = ^din[DATA_W-1:LW];
        end
    end else begin : g_one
        // The whole offset fits in one word.
        always_comb nxt = din[OFS_W-1:0];
        logic unused_one;
        assign unused_one = ^{cur, word_hi};
        if (DATA_W > OFS_W) begin : g_sink
            logic unused_din_top;
            assign unused_din_top = ^din[DATA_W-1:OFS_W];
        end
    end
endmodule

// File: rtl/ofs_rd_port.sv
// Module: read-back port in the read clock domain.
// Walks its own word sequence (almost-empty first, low word first) and
// registers the selected word, zero-extended, onto the output bus.
// Assumes the offsets are quasi-static while being read back.
module ofs_rd_port #(
    parameter int OFS_W  = 18,
    parameter int DATA_W = 18,
    parameter int NW     = 2
) (
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              rd_go,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    output logic [DATA_W-1:0] rb_data
);
    localparam int LW    = ofl_pkg::PAR_WORD_W;
    localparam int NSTEP = 2 * NW;
    localparam int SW    = $clog2(NSTEP);

    logic              clr_n;
    logic [SW-1:0]     rstep;
    logic              pick_af;
    logic [OFS_W-1:0]  sel_ofs;
    logic [DATA_W-1:0] word;

    assign clr_n = mrst_n && prst_n;

    ofs_seq_ctr #(.MAX(NSTEP)) u_rseq (
        .clk   (rclk),
        .clr_n (clr_n),
        .adv   (rd_go),
        .cnt   (rstep)
    );

    // Register selection: the second half of the sequence is almost-full.
    always_comb begin
        pick_af = (rstep >= SW'(NW));
        sel_ofs = pick_af ? af_ofs : ae_ofs;
    end

    if (NW == 2) begin : g_two
        // Word selection: odd steps carry the upper bits.
        always_comb begin
            if (rstep[0]) begin
                word = DATA_W'(sel_ofs[OFS_W-1:LW]);
            end else begin
                word = DATA_W'(sel_ofs[LW-1:0]);
            end
        end
    end else begin : g_one
        // The whole offset is one word.
        always_comb word = DATA_W'(sel_ofs);
    end

    // Output register: clear on any reset, load on a read-back strobe.
    always_ff @(posedge rclk) begin
        if (!clr_n) begin
            rb_data <= '0;
        end else if (rd_go) begin
            rb_data <= word;
        end
    end
endmodule

// File: rtl/flag_offset_loader.sv
// Module: holds the almost-empty and almost-full offsets for the queue flag
// logic. Presets at master reset, parallel write on wclk, serial shift on
// wclk, parallel read-back on rclk. Flags invalid while mid-programming.
// Assumes both resets and cfg_sel are stable around both clocks' edges.
module flag_offset_loader #(
    parameter int OFS_W  = 18,
    parameter int DATA_W = 18
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              cfg_sel,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic              ser_en_n,
    input  logic              ser_din,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  ae_offset,
    output logic [OFS_W-1:0]  af_offset,
    output logic [DATA_W-1:0] rb_data,
    output logic              flags_invalid
);
    import ofl_pkg::*;

    localparam int NW    = (OFS_W > PAR_WORD_W) ? 2 : 1;
    localparam int NSTEP = 2 * NW;
    localparam int NBITS = 2 * OFS_W;
    localparam int SW    = $clog2(NSTEP);
    localparam int BW    = $clog2(NBITS);

    wr_op_e           op;
    logic             seq_clr_n;
    logic [SW-1:0]    wstep;
    logic [BW-1:0]    sbit;
    logic             tgt_af;
    logic             word_hi;
    logic [OFS_W-1:0] ae_q, af_q, ae_nx, af_nx;
    logic [OFS_W-1:0] mrg_cur, mrg_nxt;
    logic [OFS_W-1:0] preset;

    // Decode the write-side operation; parallel write wins over serial.
    always_comb begin
        op = OP_IDLE;
        if (!cfg_sel) begin
            if (!wr_en_n) begin
                op = OP_PWR;
            end else if (!ser_en_n) begin
                op = OP_SHIFT;
            end
        end
    end

    assign seq_clr_n = mrst_n && prst_n;

    ofs_seq_ctr #(.MAX(NSTEP)) u_wseq (
        .clk   (wclk),
        .clr_n (seq_clr_n),
        .adv   (op == OP_PWR),
        .cnt   (wstep)
    );

    ofs_seq_ctr #(.MAX(NBITS)) u_sbit (
        .clk   (wclk),
        .clr_n (seq_clr_n),
        .adv   (op == OP_SHIFT),
        .cnt   (sbit)
    );

    // Target register of the current parallel step.
    assign tgt_af = (wstep >= SW'(NW));

    if (NW == 2) begin : g_hi
        assign word_hi = wstep[0];
    end else begin : g_nohi
        assign word_hi = 1'b0;
    end

    assign mrg_cur = tgt_af ? af_q : ae_q;

    ofs_word_merge #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_merge (
        .cur     (mrg_cur),
        .din     (din),
        .word_hi (word_hi),
        .nxt     (mrg_nxt)
    );

    // Next offset values for a parallel write or a serial shift.
    always_comb begin
        ae_nx = ae_q;
        af_nx = af_q;
        case (op)
            OP_PWR: begin
                if (tgt_af) begin
                    af_nx = mrg_nxt;
                end else begin
                    ae_nx = mrg_nxt;
                end
            end
            OP_SHIFT: begin
                {af_nx, ae_nx} = {ser_din, af_q, ae_q[OFS_W-1:1]};
            end
            default: begin
                ae_nx = ae_q;
                af_nx = af_q;
            end
        endcase
    end

    // Preset chosen by the select level during master reset.
    assign preset = cfg_sel ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);

    // Offset registers: preset on master reset, hold on partial reset.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            ae_q <= preset;
            af_q <= preset;
        end else if (prst_n) begin
            ae_q <= ae_nx;
            af_q <= af_nx;
        end
    end

    ofs_rd_port #(.OFS_W(OFS_W), .DATA_W(DATA_W), .NW(NW)) u_rd (
        .rclk    (rclk),
        .mrst_n  (mrst_n),
        .prst_n  (prst_n),
        .rd_go   (!cfg_sel && !rd_en_n),
        .ae_ofs  (ae_q),
        .af_ofs  (af_q),
        .rb_data (rb_data)
    );

    assign ae_offset     = ae_q;
    assign af_offset     = af_q;
    assign flags_invalid = (wstep != '0) || (sbit != '0);
endmodule

// File: rtl/flag_offset_loader_chk.sv
// Module: assertion checker bound to flag_offset_loader. Relates the block's
// ports across clock edges. Assumes inputs are stable around both clocks.
module flag_offset_loader_chk #(
    parameter int OFS_W  = 18,
    parameter int DATA_W = 18
) (
    input logic              wclk,
    input logic              rclk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              cfg_sel,
    input logic              rd_en_n,
    input logic [OFS_W-1:0]  ae_offset,
    input logic [OFS_W-1:0]  af_offset,
    input logic [DATA_W-1:0] rb_data,
    input logic              flags_invalid
);
    p_preset_lo_r1: assert property (@(posedge wclk) disable iff (!mrst_n)
        ($rose(mrst_n) && !$past(cfg_sel)) |->
        (ae_offset == OFS_W'(ofl_pkg::DEF_LO) && af_offset == OFS_W'(ofl_pkg::DEF_LO)));

    p_preset_hi_r2: assert property (@(posedge wclk) disable iff (!mrst_n)
        ($rose(mrst_n) && $past(cfg_sel)) |->
        (ae_offset == OFS_W'(ofl_pkg::DEF_HI) && af_offset == OFS_W'(ofl_pkg::DEF_HI)));

    p_partial_keep_r3: assert property (@(posedge wclk) disable iff (!mrst_n)
        !prst_n |=> ($stable(ae_offset) && $stable(af_offset) && !flags_invalid));

    p_rb_hold_r5: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (rd_en_n || cfg_sel) |=> $stable(rb_data));

    p_blocked_r7: assert property (@(posedge wclk) disable iff (!mrst_n)
        (cfg_sel && prst_n) |=>
        ($stable(ae_offset) && $stable(af_offset) && $stable(flags_invalid)));

    p_valid_after_reset_r8: assert property (@(posedge wclk) disable iff (!mrst_n)
        $rose(mrst_n) |-> !flags_invalid);
endmodule

bind flag_offset_loader flag_offset_loader_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
    .wclk          (wclk),
    .rclk          (rclk),
    .mrst_n        (mrst_n),
    .prst_n        (prst_n),
    .cfg_sel       (cfg_sel),
    .rd_en_n       (rd_en_n),
    .ae_offset     (ae_offset),
    .af_offset     (af_offset),
    .rb_data       (rb_data),
    .flags_invalid (flags_invalid)
);

// File: tb/sim_flag_offset_loader.sv
module sim_flag_offset_loader;
    localparam int OW  = 18;
    localparam int DW  = 18;
    localparam int NWB = (OW > 16) ? 2 : 1;
    localparam int NSB = 2 * NWB;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1, cfg_sel = 1'b1;
    logic          wr_en_n = 1'b1, rd_en_n = 1'b1, ser_en_n = 1'b1, ser_din = 1'b0;
    logic [DW-1:0] din = '0;
    logic [OW-1:0] ae_offset, af_offset;
    logic [DW-1:0] rb_data;
    logic          flags_invalid;

    logic [OW-1:0] m_ae = '0, m_af = '0;
    logic [DW-1:0] m_rb = '0;
    int            m_ws = 0, m_sb = 0, m_rs = 0;
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    flag_offset_loader #(.OFS_W(OW), .DATA_W(DW)) u0 (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_sel(cfg_sel), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
        .ser_en_n(ser_en_n), .ser_din(ser_din), .din(din),
        .ae_offset(ae_offset), .af_offset(af_offset), .rb_data(rb_data),
        .flags_invalid(flags_invalid));

    always #10 wclk = ~wclk;
    initial begin
        #5;
        forever #10 rclk = ~rclk;
    end

    function automatic logic [OW-1:0] f_merge(logic [OW-1:0] cur, logic [DW-1:0] d, bit hi);
        logic [OW-1:0] r = cur;
        if (NWB == 1) return OW'(d);
        for (int i = 0; i < OW; i++) begin
            if (hi && i >= 16) r[i] = d[i-16];
            if (!hi && i < 16) r[i] = d[i];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] f_pick(logic [OW-1:0] v, bit hi);
        if (NWB == 1) return DW'(v);
        return hi ? DW'(v >> 16) : DW'(v & OW'(16'hFFFF));
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " ae_offset"}, 64'(ae_offset), 64'(m_ae));
        check({tag, " af_offset"}, 64'(af_offset), 64'(m_af));
        check({tag, " rb_data"}, 64'(rb_data), 64'(m_rb));
        check({tag, " flags_invalid R8"}, 64'(flags_invalid), 64'((m_ws != 0) || (m_sb != 0)));
    endtask

    task automatic go_idle();
        cfg_sel = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; ser_en_n = 1'b1;
        mrst_n = 1'b1; prst_n = 1'b1;
    endtask

    task automatic finish_op(input string tag);
        @(negedge wclk);
        go_idle();
        #1;
        check_all(tag);
    endtask

    task automatic op_mrst(input bit sel, input string tag);
        @(negedge wclk);
        mrst_n = 1'b0; cfg_sel = sel;
        m_ae = sel ? OW'(1023) : OW'(127);
        m_af = m_ae;
        m_ws = 0; m_sb = 0; m_rs = 0; m_rb = '0;
        finish_op(tag);
    endtask

    task automatic op_prst(input string tag);
        @(negedge wclk);
        prst_n = 1'b0;
        cfg_sel = 1'($urandom_range(0, 1));
        m_ws = 0; m_sb = 0; m_rs = 0; m_rb = '0;
        finish_op(tag);
    endtask

    task automatic op_write(input logic [DW-1:0] d, input bit with_ser, input string tag);
        @(negedge wclk);
        cfg_sel = 1'b0; wr_en_n = 1'b0; din = d;
        ser_en_n = !with_ser; ser_din = 1'($urandom_range(0, 1));
        if (m_ws >= NWB) m_af = f_merge(m_af, d, bit'(m_ws % NWB));
        else m_ae = f_merge(m_ae, d, bit'(m_ws % NWB));
        m_ws = (m_ws + 1) % NSB;
        finish_op(tag);
    endtask

    task automatic op_shift(input bit b, input string tag);
        @(negedge wclk);
        cfg_sel = 1'b0; ser_en_n = 1'b0; ser_din = b;
        {m_af, m_ae} = {b, m_af, m_ae[OW-1:1]};
        m_sb = (m_sb + 1) % (2 * OW);
        finish_op(tag);
    endtask

    task automatic op_read(input string tag);
        @(negedge wclk);
        cfg_sel = 1'b0; rd_en_n = 1'b0;
        m_rb = f_pick((m_rs >= NWB) ? m_af : m_ae, bit'(m_rs % NWB));
        m_rs = (m_rs + 1) % NSB;
        finish_op(tag);
    endtask

    task automatic op_blocked(input string tag);
        @(negedge wclk);
        cfg_sel = 1'b1;
        wr_en_n = 1'($urandom_range(0, 1)); rd_en_n = 1'($urandom_range(0, 1));
        ser_en_n = 1'($urandom_range(0, 1)); ser_din = 1'($urandom_range(0, 1));
        din = DW'($urandom);
        finish_op(tag);
    endtask

    initial begin
        logic [2*OW-1:0] pat;
        void'($urandom(32'd1357));
        #1;
        // Reset presets
        op_mrst(1'b0, "R1 preset low");
        op_mrst(1'b1, "R2 preset high");
        // Parallel write order and wrap
        op_write(DW'(18'h0ABCD), 1'b0, "R4 ae low word");
        op_write(DW'(18'h00002), 1'b0, "R4 ae high word");
        op_write(DW'(18'h01234), 1'b0, "R4 af low word");
        op_write(DW'(18'h00001), 1'b0, "R4 af high word");
        op_write(DW'(18'h05555), 1'b0, "R4 wrap to ae low");
        // Read-back order, zero-extended upper word
        op_read("R5 rb ae low");
        op_read("R5 rb ae high");
        op_read("R5 rb af low");
        op_read("R5 rb af high R10");
        op_read("R5 rb wrap");
        // Partial reset mid-sequence keeps values
        op_prst("R3 partial reset");
        op_write(DW'(18'h0FFFF), 1'b1, "R9 parallel wins over serial");
        op_blocked("R7 blocked strobes");
        op_prst("R3 partial reset again");
        // Full serial load
        op_mrst(1'b0, "R1 preset low again");
        pat = {18'h2C3A5, 18'h15A0F};
        for (int i = 0; i < 2 * OW; i++) op_shift(pat[i], "R6 serial shift");
        check("R6 serial ae", 64'(ae_offset), 64'(pat[OW-1:0]));
        check("R6 serial af", 64'(af_offset), 64'(pat[2*OW-1:OW]));
        // Random mix
        for (int k = 0; k < 600; k++) begin
            int sel;
            sel = int'($urandom_range(0, 99));
            if (sel < 2) op_mrst(1'($urandom_range(0, 1)), "R1 R2 random master reset");
            else if (sel < 6) op_prst("R3 random partial reset");
            else if (sel < 30) op_write(DW'($urandom), 1'b0, "R4 random write");
            else if (sel < 36) op_write(DW'($urandom), 1'b1, "R9 random both strobes");
            else if (sel < 60) op_shift(1'($urandom_range(0, 1)), "R6 random shift");
            else if (sel < 82) op_read("R5 R10 random read");
            else op_blocked("R7 random blocked");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule